// File: doc/BRIEF.md
# Address Watchpoint Match Unit

This block holds a small bank of address watchpoints that a processor checks on every instruction fetch and every data load or store. Each watchpoint has two 32-bit registers. The address register holds a doubleword address and per-access-type enables. The control register holds an address-space filter, a global bypass, a region mask and sticky hit indicators. Software reaches both registers through a simple register port. When an enabled watchpoint matches an access, the block raises a one-cycle watch exception request.

Some watchpoints serve the fetch side only and the rest serve the data side only. Enables that make no sense for a side are held at zero. If the processor is already handling an exception or an error when a match occurs, no request is raised at that time. The match is remembered, and the request is raised, marked as deferred, as soon as both status levels are clear again.

Top module: `watch_match_unit`

## Requirements
- R1: The unit has NUM_PAIRS watchpoints (default 4). Watchpoints 0 to NUM_FETCH-1 (default 0 and 1) watch fetches only. The others watch data accesses only. The register index is `reg_addr = {pair, sel}`: sel 0 selects the address register and sel 1 the control register. `reg_rdata` returns the selected register one cycle after `reg_addr` is presented.
- R2: Address register fields: bits 31:3 hold the address, bit 2 is the fetch enable, bit 1 the load enable and bit 0 the store enable. The register resets to zero.
- R3: On fetch watchpoints, bits 1:0 of the address register read as 0 and ignore writes. On data watchpoints, bit 2 reads as 0 and ignores writes.
- R4: Address bits 2:0 take no part in the comparison, so one watchpoint covers an aligned 8-byte doubleword.
- R5: Control bits 11:3 form a mask. A 1 in mask bit n removes address bit n from the comparison.
- R6: Control register fields: bit 31 reads 1 on every watchpoint except the last, where it reads 0. Bit 30 is global, bits 23:16 are the address-space ID and bits 11:3 the mask. All other bits except 2:0 read as zero. Apart from bit 31, the register resets to zero.
- R7: A match requires the access's address-space ID to equal the programmed ID, unless the global bit is set.
- R8: Control bits 2:0 (fetch, load, store) are sticky hit indicators. Each is set by a match of that access type and cleared only by writing 1 to it. When a match and a clear arrive in the same cycle, the match wins.
- R9: A match while `st_exl` and `st_erl` are both low gives `watch_req` high for exactly the next cycle, with `watch_deferred` low.
- R10: A match while `st_exl` or `st_erl` is high raises no request and is held as pending. In the cycle after both inputs are low, `watch_req` and `watch_deferred` pulse high together and the pending state clears.
- R11: A watchpoint matches only an access type whose enable is set: a load never matches a store-only watchpoint, and a data access never matches a fetch watchpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Register index {pair, sel} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| if_valid | input | 1 | Fetch access valid |
| if_vaddr | input | 32 | Fetch virtual address |
| if_asid | input | 8 | Fetch address-space ID |
| dm_valid | input | 1 | Data access valid |
| dm_store | input | 1 | Data access is a store (0 means load) |
| dm_vaddr | input | 32 | Data virtual address |
| dm_asid | input | 8 | Data address-space ID |
| st_exl | input | 1 | Exception-level status |
| st_erl | input | 1 | Error-level status |
| watch_req | output | 1 | Watch exception request pulse |
| watch_deferred | output | 1 | Marks a request that was held during exception mode |

## Verification
The bench builds the unit with its defaults, four pairs of which two are fetch pairs. This brings both sides, the zeroed enables of each side and the end of the "more follows" chain within reach. A table of fetches, loads and stores is run against four differently programmed pairs: exact and masked addresses, an ID mismatch, a global pair and wrong access types. Directed tests then cover reset values, reserved bits, the sticky write-1-to-clear indicators, and deferral under both the exception and the error status inputs.

// File: rtl/wmu_pkg.sv
package wmu_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned VADDR_W = 32;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned GRAN_W  = 3;   // doubleword granule
  localparam int unsigned MASK_LO = 3;
  localparam int unsigned MASK_HI = 11;
  localparam int unsigned MASK_W  = MASK_HI - MASK_LO + 1;
  localparam int unsigned CTL_MORE_BIT = 31;
  localparam int unsigned CTL_GLB_BIT  = 30;
  localparam int unsigned CTL_ASID_LO  = 16;

  typedef struct packed {
    logic                valid;
    logic                store;
    logic [VADDR_W-1:0]  vaddr;
    logic [ASID_W-1:0]   asid;
  } wmu_acc_t;
endpackage

// File: rtl/wmu_pair.sv
module wmu_pair
  import wmu_pkg::*;
#(
  parameter bit IS_FETCH = 1'b1,
  parameter bit HAS_MORE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_addr_reg,
  input  logic             wr_ctl_reg,
  input  logic [REG_W-1:0] wdata,
  input  wmu_acc_t         acc,
  output logic [REG_W-1:0] rd_addr_reg,
  output logic [REG_W-1:0] rd_ctl_reg,
  output logic             hit
);
  localparam logic [2:0] EN_KEEP = IS_FETCH ? 3'b100 : 3'b011;

  logic [VADDR_W-1:GRAN_W] wp_addr_q;
  logic [2:0]              en_q;
  logic                    glb_q;
  logic [ASID_W-1:0]       asid_q;
  logic [MASK_W-1:0]       mask_q;
  logic [2:0]              seen_q;

  logic [VADDR_W-1:0] care;
  logic               addr_eq;
  logic               asid_ok;
  logic [2:0]         kind;
  logic [2:0]         hits3;

  // Compare path
  always_comb begin
    care = '1;
    care[GRAN_W-1:0] = '0;
    care[MASK_HI:MASK_LO] = ~mask_q;
    addr_eq = ((acc.vaddr ^ {wp_addr_q, {GRAN_W{1'b0}}}) & care) == '0;
    asid_ok = glb_q || (acc.asid == asid_q);
    if (IS_FETCH) kind = {acc.valid, 2'b00};
    else          kind = {1'b0, acc.valid && !acc.store, acc.valid && acc.store};
    hits3 = kind & en_q & {3{addr_eq && asid_ok}};
  end

  assign hit = |hits3;

  // Register state
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_addr_q <= '0;
      en_q      <= '0;
      glb_q     <= 1'b0;
      asid_q    <= '0;
      mask_q    <= '0;
      seen_q    <= '0;
    end else begin
      if (wr_addr_reg) begin
        wp_addr_q <= wdata[VADDR_W-1:GRAN_W];
        en_q      <= wdata[2:0] & EN_KEEP;
      end
      if (wr_ctl_reg) begin
        glb_q  <= wdata[CTL_GLB_BIT];
        asid_q <= wdata[CTL_ASID_LO +: ASID_W];
        mask_q <= wdata[MASK_HI:MASK_LO];
      end
      seen_q <= (seen_q & ~(wr_ctl_reg ? wdata[2:0] : 3'b000)) | hits3;
    end
  end

  assign rd_addr_reg = {wp_addr_q, en_q};
  assign rd_ctl_reg  = {HAS_MORE, glb_q, 6'b0, asid_q, 4'b0, mask_q, seen_q};

  // A match of a type always leaves that indicator set
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
    (|hits3) |=> ((seen_q & $past(hits3)) == $past(hits3)));

  // Without a control write, no indicator is lost
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_ctl_reg |=> ((seen_q & $past(seen_q)) == $past(seen_q)));
endmodule

// File: rtl/wmu_excp.sv
module wmu_excp (
  input  logic clk,
  input  logic rst,
  input  logic any_hit,
  input  logic st_exl,
  input  logic st_erl,
  output logic req,
  output logic deferred
);
  logic in_exc;
  logic pend_q;

  assign in_exc = st_exl || st_erl;

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      deferred <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      req      <= 1'b0;
      deferred <= 1'b0;
      if (!in_exc) begin
        if (any_hit || pend_q) begin
          req      <= 1'b1;
          deferred <= pend_q;
        end
        pend_q <= 1'b0;
      end else if (any_hit) begin
        pend_q <= 1'b1;
      end
    end
  end

  assert_quiet_in_exc_R10: assert property (@(posedge clk) disable iff (rst)
    in_exc |=> !req);

  assert_hold_pending_R10: assert property (@(posedge clk) disable iff (rst)
    (any_hit && in_exc) |=> pend_q);

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !in_exc) |=> (req && deferred && !pend_q));

  assert_prompt_req_R9: assert property (@(posedge clk) disable iff (rst)
    (any_hit && !in_exc) |=> req);

  assert_deferred_only_with_req_R9: assert property (@(posedge clk) disable iff (rst)
    deferred |-> req);
endmodule

// File: rtl/watch_match_unit.sv
module watch_match_unit
  import wmu_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned NUM_FETCH = 2,
  localparam int unsigned IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [IDX_W:0]     reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               if_valid,
  input  logic [VADDR_W-1:0] if_vaddr,
  input  logic [ASID_W-1:0]  if_asid,
  input  logic               dm_valid,
  input  logic               dm_store,
  input  logic [VADDR_W-1:0] dm_vaddr,
  input  logic [ASID_W-1:0]  dm_asid,
  input  logic               st_exl,
  input  logic               st_erl,
  output logic               watch_req,
  output logic               watch_deferred
);
  wmu_acc_t fetch_acc;
  wmu_acc_t data_acc;
  logic [REG_W-1:0] rd_a [NUM_PAIRS];
  logic [REG_W-1:0] rd_c [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] pair_hit;
  logic [IDX_W-1:0] sel_pair;

  assign fetch_acc = '{valid: if_valid, store: 1'b0, vaddr: if_vaddr, asid: if_asid};
  assign data_acc  = '{valid: dm_valid, store: dm_store, vaddr: dm_vaddr, asid: dm_asid};
  assign sel_pair  = reg_addr[IDX_W:1];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic sel_here;
    assign sel_here = reg_wr && (sel_pair == IDX_W'(p));
    wmu_pair #(
      .IS_FETCH(p < NUM_FETCH),
      .HAS_MORE(p < NUM_PAIRS - 1)
    ) i_pair (
      .clk         (clk),
      .rst         (rst),
      .wr_addr_reg (sel_here && !reg_addr[0]),
      .wr_ctl_reg  (sel_here && reg_addr[0]),
      .wdata       (reg_wdata),
      .acc         ((p < NUM_FETCH) ? fetch_acc : data_acc),
      .rd_addr_reg (rd_a[p]),
      .rd_ctl_reg  (rd_c[p]),
      .hit         (pair_hit[p])
    );
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_addr[0] ? rd_c[sel_pair] : rd_a[sel_pair];
  end

  wmu_excp i_excp (
    .clk      (clk),
    .rst      (rst),
    .any_hit  (|pair_hit),
    .st_exl   (st_exl),
    .st_erl   (st_erl),
    .req      (watch_req),
    .deferred (watch_deferred)
  );

  // Data-side accesses never reach fetch pairs and vice versa
  assert_side_split_R11: assert property (@(posedge clk) disable iff (rst)
    !if_valid |-> (pair_hit[NUM_FETCH-1:0] == '0));
endmodule

// File: tb/test_watch_match_unit.sv
module test_watch_match_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        if_valid = 1'b0;
  logic [31:0] if_vaddr = '0;
  logic [7:0]  if_asid = '0;
  logic        dm_valid = 1'b0;
  logic        dm_store = 1'b0;
  logic [31:0] dm_vaddr = '0;
  logic [7:0]  dm_asid = '0;
  logic        st_exl = 1'b0;
  logic        st_erl = 1'b0;
  logic        watch_req;
  logic        watch_deferred;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  watch_match_unit i_watch_match_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .if_valid(if_valid), .if_vaddr(if_vaddr), .if_asid(if_asid),
    .dm_valid(dm_valid), .dm_store(dm_store), .dm_vaddr(dm_vaddr), .dm_asid(dm_asid),
    .st_exl(st_exl), .st_erl(st_erl),
    .watch_req(watch_req), .watch_deferred(watch_deferred)
  );

  // {kind[1:0] (0 fetch,1 load,2 store), addr[31:0], asid[7:0], expect_req}
  localparam logic [42:0] VEC [13] = '{
    {2'd0, 32'h0000_1000, 8'd5,  1'b1},  // R1 fetch pair 0 exact
    {2'd0, 32'h0000_1007, 8'd5,  1'b1},  // R4 low bits ignored
    {2'd0, 32'h0000_1008, 8'd5,  1'b0},  // R4 next doubleword
    {2'd0, 32'h0000_1000, 8'd6,  1'b0},  // R7 ID mismatch
    {2'd0, 32'h0000_2000, 8'd33, 1'b1},  // R7 global pair
    {2'd0, 32'h0000_2010, 8'd1,  1'b1},  // R5 masked bit 4
    {2'd0, 32'h0000_2020, 8'd1,  1'b0},  // R5 unmasked bit 5
    {2'd1, 32'h0000_3004, 8'd7,  1'b1},  // R2 load pair 2
    {2'd2, 32'h0000_3000, 8'd7,  1'b0},  // R11 store vs load-only
    {2'd2, 32'h0000_4000, 8'd9,  1'b1},  // R2 store pair 3
    {2'd1, 32'h0000_4000, 8'd9,  1'b0},  // R11 load vs store-only
    {2'd0, 32'h0000_3000, 8'd7,  1'b0},  // R11 fetch vs data pair
    {2'd1, 32'h0000_1000, 8'd5,  1'b0}   // R11 load vs fetch pair
  };
  string vtag [13] = '{"R1","R4","R4","R7","R7","R5","R5","R2","R11","R2","R11","R11","R11"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    check(tag, v, exp);
  endtask

  // Drives one access for one cycle, then samples the request it produced
  task automatic access(input logic [1:0] kind, input logic [31:0] a, input logic [7:0] id);
    @(negedge clk);
    if (kind == 2'd0) begin
      if_valid = 1'b1; if_vaddr = a; if_asid = id;
    end else begin
      dm_valid = 1'b1; dm_store = (kind == 2'd2); dm_vaddr = a; dm_asid = id;
    end
    @(negedge clk);
    if_valid = 1'b0; dm_valid = 1'b0; dm_store = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state (R2, R6, R9)
    check("R9 reset req", {31'b0, watch_req}, 32'd0);
    for (int p = 0; p < 4; p++) begin
      rd_check("R2 reset addr reg", 3'(2*p), 32'h0);
      rd_check("R6 reset ctl reg", 3'(2*p+1), (p < 3) ? 32'h8000_0000 : 32'h0);
    end
    // Reserved bits and chain end (R6)
    wr_reg(3'd7, 32'hFFFF_FFFF);
    rd_check("R6 reserved bits", 3'd7, 32'h40FF_0FF8);
    // Side enables tied off (R3)
    wr_reg(3'd0, 32'h0000_1007);
    rd_check("R3 fetch pair drops load/store", 3'd0, 32'h0000_1004);
    wr_reg(3'd4, 32'h0000_3006);
    rd_check("R3 data pair drops fetch", 3'd4, 32'h0000_3002);
    wr_reg(3'd2, 32'h0000_2004);
    wr_reg(3'd6, 32'h0000_4001);
    wr_reg(3'd1, 32'h0005_0000);
    rd_check("R6 asid field", 3'd1, 32'h8005_0000);
    wr_reg(3'd3, 32'h4000_0010);
    wr_reg(3'd5, 32'h0007_0000);
    wr_reg(3'd7, 32'h0009_0000);
    rd_check("R6 last pair", 3'd7, 32'h0009_0000);

    // Vector table
    for (int i = 0; i < 13; i++) begin
      access(VEC[i][42:41], VEC[i][40:9], VEC[i][8:1]);
      check({vtag[i], " req"}, {31'b0, watch_req}, {31'b0, VEC[i][0]});
      check({vtag[i], " not deferred"}, {31'b0, watch_deferred}, 32'd0);
      @(negedge clk);
      check("R9 single pulse", {31'b0, watch_req}, 32'd0);
    end

    // Sticky indicators (R8)
    rd_check("R8 fetch indicator", 3'd1, 32'h8005_0004);
    rd_check("R8 load indicator", 3'd5, 32'h8007_0002);
    rd_check("R8 store indicator", 3'd7, 32'h0009_0001);
    wr_reg(3'd5, 32'h0007_0000);
    rd_check("R8 write 0 keeps", 3'd5, 32'h8007_0002);
    wr_reg(3'd1, 32'h0005_0004);
    rd_check("R8 write 1 clears", 3'd1, 32'h8005_0000);

    // Deferral under exception level (R10)
    st_exl = 1'b1;
    access(2'd0, 32'h0000_1000, 8'd5);
    check("R10 no req in exl", {31'b0, watch_req}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 still held", {31'b0, watch_req}, 32'd0);
    st_exl = 1'b0;
    @(negedge clk);
    check("R10 deferred req", {30'b0, watch_req, watch_deferred}, 32'd3);
    @(negedge clk);
    check("R10 pending cleared", {31'b0, watch_req}, 32'd0);

    // Deferral under error level, released only when both clear (R10)
    st_erl = 1'b1;
    access(2'd2, 32'h0000_4000, 8'd9);
    st_exl = 1'b1;
    @(negedge clk);
    st_erl = 1'b0;
    @(negedge clk);
    check("R10 exl still blocks", {31'b0, watch_req}, 32'd0);
    st_exl = 1'b0;
    @(negedge clk);
    check("R10 deferred after erl", {30'b0, watch_req, watch_deferred}, 32'd3);
    @(negedge clk);
    check("R10 one pulse", {31'b0, watch_req}, 32'd0);

    // A normal hit has no deferred mark (R9)
    access(2'd1, 32'h0000_3000, 8'd7);
    check("R9 prompt req", {30'b0, watch_req, watch_deferred}, 32'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule